// File: doc/BRIEF.md
# CAN Zero-Frame Bit-Rate Detector

This block works out the bit period of a CAN bus from a single reference frame. The frame has a standard identifier of zero and a data length of zero. Once stuff bits are added, its start on the wire is a fixed run of dominant and recessive bits: five dominant, one recessive, repeated five times. The block samples the receive line with the system clock and starts a cycle counter on the first dominant sample. It stops the counter at the leading edge of the fifth qualified recessive bit, which is exactly 29 bit times later. A sequential divider then turns that interval into a rounded bit period in clock cycles. Spreading the measurement over 29 bits keeps the sampling error small.

The block is used while a node is first brought up. It is armed by raising `en_i`, and the result is read when `done_o` pulses. The result is a single word that is produced once and then held, so it leaves on a plain output with a one-cycle strobe rather than a valid/ready stream. Nothing can back-pressure it, and `period_o` keeps its value until the next measurement completes. A short recessive spike can be rejected by setting a minimum run length on `min_rec_i`.

Top module: `can_bitrate_detect`

## Requirements
- R1: While reset is asserted and at the first sample after it is released, `period_o` is 0 and `done_o` and `err_o` are 0.
- R2: While `en_i` is low, bus activity causes no `done_o` pulse and does not set `err_o`.
- R3: The raw line passes through a two-stage synchroniser. Timing starts on the first synchronised low (dominant) sample seen while armed. It stops on the first high sample of the fifth qualified recessive run, so an ideal frame with P cycles per bit measures 29*P cycles.
- R4: The reported period is floor((count + 14) / 29), which is the count divided by 29 and rounded to the nearest integer.
- R5: `done_o` is high for exactly one clock, and `period_o` carries the new result in that same cycle.
- R6: A recessive run counts as a recessive bit only if it lasts at least `min_rec_i` consecutive samples; a value of 0 acts as 1. A shorter recessive spike is ignored, and a run of exactly `min_rec_i` samples is counted.
- R7: If the counter reaches its all-ones value before the fifth recessive bit, `err_o` is set and no result is produced. The block re-arms, and `err_o` stays high until `en_i` falls.
- R8: After a result, further frames cause no `done_o` and do not change `period_o` until `en_i` has been lowered and raised again.
- R9: Lowering `en_i` aborts a measurement in progress and clears `err_o` at the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Arms the detector while high; a low level aborts and clears the error |
| rx_i | input | 1 | Raw CAN receive line, low is dominant |
| min_rec_i | input | REC_W | Minimum recessive run length, in samples, for a run to count as a bit |
| period_o | output | CNT_W | Measured bit period in clock cycles |
| done_o | output | 1 | One-cycle strobe when a new period is valid |
| err_o | output | 1 | Counter overflowed before the fifth recessive bit |

## Verification
Two situations are hardest to reach from the ports. The first is the exact qualification boundary of a recessive run, where a run of exactly `min_rec_i` samples must count and one sample fewer must not. The bench reaches it by setting the minimum equal to the bit length across a sweep of periods, and by cutting a spike into the first dominant run that is either one sample short of the minimum or exactly at it. The second is counter overflow, which needs a frame slow enough to exhaust a narrowed counter. The bench uses a 10-bit counter and a stretched bit, and then checks that the error stays set while the restarted measurement on the idle line never finishes.

// File: rtl/can_brd_pkg.sv
package can_brd_pkg;
  // number of bit times between first dominant and fifth recessive edge
  localparam int unsigned FRAME_BITS = 29;
  // recessive bit whose leading edge stops the timer
  localparam int unsigned STOP_REC   = 5;
  // rounding bias for the division
  localparam int unsigned ROUND_BIAS = FRAME_BITS / 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DIV,
    ST_DONE
  } brd_state_e;
endpackage

// File: rtl/brd_sync.sv
module brd_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/brd_run_timer.sv
module brd_run_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned REC_W = 8,
  parameter int unsigned NREC  = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             rx_i,
  input  logic [REC_W-1:0] min_rec_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam int unsigned      RC_W    = $clog2(NREC + 1);

  logic [CNT_W-1:0] cnt_q, cand_q;
  logic [REC_W-1:0] rlen_q, rlen_d, min_eff;
  logic [RC_W-1:0]  rcnt_q;
  logic             rx_q, rise, qualify;

  assign min_eff = (min_rec_i == '0) ? REC_W'(1) : min_rec_i;
  assign rise    = rx_i & ~rx_q;

  // length of the current recessive run, saturating at the threshold
  always_comb begin
    rlen_d = rlen_q;
    if (!rx_i)                rlen_d = '0;
    else if (rise)            rlen_d = REC_W'(1);
    else if (rlen_q < min_eff) rlen_d = rlen_q + 1'b1;
  end

  assign qualify = run_i & rx_i & (rlen_d == min_eff) & (rise | (rlen_q < min_eff));
  assign meas_o  = rise ? cnt_q : cand_q;
  assign hit_o   = qualify & (rcnt_q == RC_W'(NREC - 1));
  assign ovf_o   = run_i & ~hit_o & (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= 1'b1;
      rlen_q <= '0;
      cnt_q  <= '0;
      cand_q <= '0;
      rcnt_q <= '0;
    end else begin
      rx_q   <= rx_i;
      rlen_q <= rlen_d;
      if (start_i) begin
        cnt_q  <= CNT_W'(1);
        rcnt_q <= '0;
      end else if (run_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (rise)    cand_q <= cnt_q;
        if (qualify) rcnt_q <= rcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/brd_const_div.sv
module brd_const_div #(
  parameter int unsigned NUM_W   = 17,
  parameter int unsigned OUT_W   = 16,
  parameter int unsigned DIVISOR = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  output logic             done_o,
  output logic [OUT_W-1:0] quo_o
);
  localparam int unsigned      DEN_W = $clog2(DIVISOR);
  localparam int unsigned      IT_W  = $clog2(NUM_W + 1);
  localparam logic [DEN_W:0]   DEN   = (DEN_W + 1)'(DIVISOR);

  logic [DEN_W-1:0] rem_q;
  logic [NUM_W-1:0] quo_q;
  logic [IT_W-1:0]  it_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   trial, diff;
  logic             take;

  assign trial = {rem_q, quo_q[NUM_W-1]};
  assign diff  = trial - DEN;
  assign take  = (trial >= DEN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      quo_q  <= '0;
      it_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start_i) begin
      rem_q  <= '0;
      quo_q  <= num_i;
      it_q   <= IT_W'(NUM_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= take ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      quo_q  <= {quo_q[NUM_W-2:0], take};
      it_q   <= it_q - 1'b1;
      busy_q <= (it_q != IT_W'(1));
      done_q <= (it_q == IT_W'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = quo_q[OUT_W-1:0];
endmodule

// File: rtl/can_bitrate_detect.sv
module can_bitrate_detect
  import can_brd_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned REC_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             rx_i,
  input  logic [REC_W-1:0] min_rec_i,
  output logic [CNT_W-1:0] period_o,
  output logic             done_o,
  output logic             err_o
);
  localparam int unsigned NUM_W = CNT_W + 1;

  brd_state_e       state_q;
  logic             rx_s, start, run, hit, ovf, div_done;
  logic [CNT_W-1:0] meas, quo;
  logic [NUM_W-1:0] num;
  logic [CNT_W-1:0] period_q;
  logic             done_q, err_q;

  brd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  assign start = en_i & (state_q == ST_IDLE) & ~rx_s;
  assign run   = en_i & (state_q == ST_RUN);

  brd_run_timer #(.CNT_W(CNT_W), .REC_W(REC_W), .NREC(STOP_REC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .run_i    (run),
    .rx_i     (rx_s),
    .min_rec_i(min_rec_i),
    .hit_o    (hit),
    .meas_o   (meas),
    .ovf_o    (ovf)
  );

  assign num = {1'b0, meas} + NUM_W'(ROUND_BIAS);

  brd_const_div #(.NUM_W(NUM_W), .OUT_W(CNT_W), .DIVISOR(FRAME_BITS)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(hit),
    .num_i  (num),
    .done_o (div_done),
    .quo_o  (quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      period_q <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
        err_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (!rx_s) state_q <= ST_RUN;
          ST_RUN: begin
            if (hit) state_q <= ST_DIV;
            else if (ovf) begin
              err_q   <= 1'b1;
              state_q <= ST_IDLE;
            end
          end
          ST_DIV: if (div_done) begin
            period_q <= quo;
            done_q   <= 1'b1;
            state_q  <= ST_DONE;
          end
          default: state_q <= ST_DONE;
        endcase
      end
    end
  end

  assign period_o = period_q;
  assign done_o   = done_q;
  assign err_o    = err_q;
endmodule

// File: rtl/can_bitrate_detect_chk.sv
module can_bitrate_detect_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CNT_W-1:0] period_o,
  input logic             done_o,
  input logic             err_o
);
  localparam logic [CNT_W:0] MAX_PER = ((CNT_W + 1)'({CNT_W{1'b1}}) + (CNT_W + 1)'(14)) / (CNT_W + 1)'(29);

  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     seen_q <= 1'b0;
    else if (!en_i)  seen_q <= 1'b0;
    else if (done_o) seen_q <= 1'b1;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  en_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!done_o && !err_o));

  // R8
  hold_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(period_o) |-> done_o);

  // R8
  single_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !seen_q);

  // R4
  period_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ({1'b0, period_o} <= MAX_PER));

  // R7
  err_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> !done_o);
endmodule

bind can_bitrate_detect can_bitrate_detect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .period_o(period_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/can_bitrate_detect_tb.sv
module can_bitrate_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 10;
  localparam int REC_W      = 6;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             en_i = 1'b0;
  logic             rx_i = 1'b1;
  logic [REC_W-1:0] min_rec_i = '0;
  logic [CNT_W-1:0] period_o;
  logic             done_o;
  logic             err_o;

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int long_pulse = 0;
  int last_period = 0;
  logic prev_done = 1'b0;

  int seg_len [14] = '{5, 1, 5, 1, 5, 1, 5, 1, 5, 1, 4, 1, 1, 11};

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  can_bitrate_detect #(.CNT_W(CNT_W), .REC_W(REC_W), .SYNC_STAGES(2)) u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .rx_i     (rx_i),
    .min_rec_i(min_rec_i),
    .period_o (period_o),
    .done_o   (done_o),
    .err_o    (err_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (done_o) begin
        done_cnt++;
        last_period = int'(period_o);
        if (prev_done) long_pulse++;
      end
      prev_done = done_o;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic lv, input int n);
    rx_i = lv;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    drive(1'b1, n);
  endtask

  task automatic frame_from(input int p, input int first);
    for (int i = first; i < 14; i++) drive((i % 2) ? 1'b1 : 1'b0, seg_len[i] * p);
  endtask

  task automatic rearm(input int minr);
    en_i = 1'b0;
    idle(3);
    min_rec_i = REC_W'(minr);
    en_i = 1'b1;
    idle(4);
  endtask

  // stretched first dominant by e cycles; expects exactly one result
  task automatic run_case(input string req, input int p, input int e, input int minr);
    int d0, exp;
    rearm(minr);
    d0 = done_cnt;
    drive(1'b0, 5 * p + e);
    frame_from(p, 1);
    idle(CNT_W + 20);
    exp = (29 * p + e + 14) / 29;
    check(req, done_cnt - d0, 1);
    check(req, last_period, exp);
    check(req, int'(period_o), exp);
  endtask

  initial begin
    repeat (1000000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d0, p0;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1", int'(period_o), 0);
    check("R1", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", int'(period_o), 0);
    check("R1", int'(done_o) + int'(err_o), 0);

    // R2 disabled: a full frame is ignored
    d0 = done_cnt;
    idle(4);
    frame_from(6, 0);
    idle(30);
    check("R2", done_cnt - d0, 0);
    check("R2", int'(err_o), 0);

    // R3 sweep of periods with ideal frames; R6 minimum 0, 1 and exactly P
    for (int p = 2; p <= 20; p++) begin
      run_case("R3", p, 0, 1);
      run_case("R6", p, 0, 0);
      run_case("R6", p, 0, p);
    end

    // R4 rounding across every residue
    for (int e = 0; e < 29; e++) run_case("R4", 6, e, 1);
    run_case("R4", 3, 14, 2);
    run_case("R4", 3, 15, 2);

    // R5 no done pulse longer than one clock
    check("R5", long_pulse, 0);

    // R8 later frame while still armed has no effect
    run_case("R8", 9, 0, 1);
    d0 = done_cnt;
    p0 = int'(period_o);
    frame_from(4, 0);
    idle(40);
    check("R8", done_cnt - d0, 0);
    check("R8", int'(period_o), p0);

    // R6 spike one short of the minimum inside first dominant run: ignored
    rearm(4);
    d0 = done_cnt;
    drive(1'b0, 16); drive(1'b1, 3); drive(1'b0, 21);
    frame_from(8, 1);
    idle(40);
    check("R6", done_cnt - d0, 1);
    check("R6", last_period, 8);

    // R6 spike exactly at the minimum: counted, stops at fourth real recessive bit
    rearm(4);
    d0 = done_cnt;
    drive(1'b0, 16); drive(1'b1, 4); drive(1'b0, 20);
    frame_from(8, 1);
    idle(40);
    check("R6", done_cnt - d0, 1);
    check("R6", last_period, (23 * 8 + 14) / 29);

    // R9 abort mid-frame, then a clean measurement
    rearm(1);
    d0 = done_cnt;
    drive(1'b0, 25); drive(1'b1, 5); drive(1'b0, 25);
    en_i = 1'b0;
    frame_from(5, 3);
    idle(40);
    check("R9", done_cnt - d0, 0);
    run_case("R9", 7, 0, 1);

    // R7 overflow: 29*40 exceeds the 10-bit counter
    rearm(1);
    d0 = done_cnt;
    frame_from(40, 0);
    idle(1200);
    check("R7", int'(err_o), 1);
    check("R7", done_cnt - d0, 0);
    // R9 lowering enable clears the error
    en_i = 1'b0;
    idle(2);
    check("R9", int'(err_o), 0);
    run_case("R7", 11, 0, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule